// File: doc/BRIEF.md
# CEC Bus Frame Receiver

This block receives frames from a single-wire consumer-electronics control bus. The line idles high. It is sampled once per count-source tick. Every falling edge restarts a tick counter. The low time measured at the following rising edge decides each bit value, and the time between two falling edges is checked against the bit period. A frame opens with a long start bit. A header block follows, then any number of data blocks. Each block is ten bits: eight data bits with the most significant bit first, then an end-of-message bit, then an acknowledge bit.

The eight data bits of the current block appear on a data output. The end-of-message bit and the acknowledge bit are held on two separate outputs. Three selectable event points raise status flags and a one-cycle interrupt pulse:
- the start bit,
- the 8th bit of a block,
- the 10th bit of a block.

A timing violation sets a sticky error flag. Reception restarts only after the enable has been held low across at least one tick and then raised again.

Top module: `cec_frame_rx`

## Requirements
- R1: After reset the data output is 0x00, the end-of-message and acknowledge outputs are 0, and all four flags and the interrupt are 0.
- R2: A start bit is accepted when its low time is 35 to 39 ticks and its full period, measured from its falling edge to the next falling edge, is 43 to 47 ticks. On the tick of that next falling edge, if `selStart` is 1, `flgStart` is set and `irq` pulses. A start low time outside 35 to 39 ticks sets `flgErr`.
- R3: A data bit with a low time of 4 to 8 ticks is a 1, and one with 13 to 17 ticks is a 0. Bits arrive most significant first. `rxData` takes the whole byte on the tick of the rising edge of the 8th bit.
- R4: On the rising edge of the 8th bit, if `selBit8` is 1, `flgBit8` is set and `irq` pulses. If `selBit8` is 0, neither happens.
- R5: On the rising edge of the 9th bit, `rxEom` takes that bit's value. On the rising edge of the 10th bit, `rxAck` takes that bit's value. Both hold between ticks.
- R6: On the rising edge of the 10th bit, `flgDone` is set whatever the selects are, and `irq` pulses only if `selBit10` is 1. An end-of-message value of 1 closes the frame. An end-of-message value of 0 expects another block.
- R7: Any of the following sets `flgErr`, which stays 1 while `rxEn` is high:
  - a data-bit low time that falls in neither window;
  - a low time beyond 17 ticks;
  - a bit period outside 21 to 28 ticks;
  - a start period beyond 47 ticks.
  While the error stands, line activity produces no events.
- R8: `rxEn` low clears `flgErr` on the next clock and abandons a frame in progress. No interrupt is raised while it is low.
- R9: `rxEn` rising after a low time that contained no tick is ignored: no event follows until `rxEn` has been low across a tick and has risen again.
- R10: `flagClr` clears `flgStart`, `flgBit8` and `flgDone` on the next clock. A flag set on the same tick wins.
- R11: `irq` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-source tick, one cycle wide |
| rxLine | input | 1 | Sampled bus line, idle high |
| rxEn | input | 1 | Receive enable |
| selStart | input | 1 | Start-bit event select |
| selBit8 | input | 1 | 8th-bit event select |
| selBit10 | input | 1 | 10th-bit event select |
| flagClr | input | 1 | Flag clear strobe or interrupt acknowledge |
| rxData | output | 8 | Last received data byte |
| rxEom | output | 1 | End-of-message bit of the current block |
| rxAck | output | 1 | Acknowledge bit of the current block |
| flgStart | output | 1 | Start bit received |
| flgBit8 | output | 1 | 8th bit received |
| flgDone | output | 1 | Block complete |
| flgErr | output | 1 | Receive error |
| irq | output | 1 | Interrupt pulse |

## Verification
The hardest situation to reach is the ignored restart. `rxEn` has to fall and rise again with no tick in between, just after an error has been latched. The bench does this by driving a single clock of low enable between two ticks. It then sends a complete, well-formed frame and expects silence on every flag and on the interrupt. Bit widths on both edges of each decode window are mixed inside one block. An over-long low is cut off on the exact tick where it passes the window, which checks the error on that tick.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
  localparam int DATA_BITS  = 8;
  localparam int BLOCK_BITS = DATA_BITS + 2;
  localparam int IDX_W      = $clog2(BLOCK_BITS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SLOW, ST_SHIGH, ST_BLOW, ST_BHIGH, ST_ERR
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic bitTake;   // a bit value was decided on this tick
    logic bitVal;    // its value
    logic bitClr;    // restart the in-block bit index
  } rxStrobe_t;
endpackage

// File: rtl/cec_rx_datapath.sv
module cec_rx_datapath
  import cec_rx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 rxLine,
  input  rxStrobe_t            strb,
  output logic                 fallSeen,
  output logic                 riseSeen,
  output logic [CNT_W-1:0]     cnt,
  output logic [IDX_W-1:0]     bitIdx,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxEom,
  output logic                 rxAck
);
  localparam logic [IDX_W-1:0] LAST_DATA = IDX_W'(DATA_BITS - 1);
  localparam logic [IDX_W-1:0] EOM_IDX   = IDX_W'(DATA_BITS);

  logic                 prevLine;
  logic [DATA_BITS-2:0] shReg;

  assign fallSeen = tick & prevLine & ~rxLine;
  assign riseSeen = tick & ~prevLine & rxLine;

  // tick counter restarted by every falling edge, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLine <= 1'b1;
      cnt      <= '0;
    end else if (tick) begin
      prevLine <= rxLine;
      if (prevLine & ~rxLine)
        cnt <= CNT_W'(1);
      else if (cnt != '1)
        cnt <= cnt + CNT_W'(1);
    end
  end

  // block deserializer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      rxData <= '0;
      rxEom  <= 1'b0;
      rxAck  <= 1'b0;
      bitIdx <= '0;
    end else begin
      if (strb.bitTake) begin
        if (bitIdx < LAST_DATA)
          shReg <= {shReg[DATA_BITS-3:0], strb.bitVal};
        else if (bitIdx == LAST_DATA)
          rxData <= {shReg, strb.bitVal};
        else if (bitIdx == EOM_IDX)
          rxEom <= strb.bitVal;
        else
          rxAck <= strb.bitVal;
      end
      if (strb.bitClr)
        bitIdx <= '0;
      else if (strb.bitTake)
        bitIdx <= bitIdx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/cec_rx_ctrl.sv
module cec_rx_ctrl
  import cec_rx_pkg::*;
#(
  parameter int CNT_W          = 6,
  parameter int START_LOW_MIN  = 35,
  parameter int START_LOW_MAX  = 39,
  parameter int START_PER_MIN  = 43,
  parameter int START_PER_MAX  = 47,
  parameter int ONE_LOW_MIN    = 4,
  parameter int ONE_LOW_MAX    = 8,
  parameter int ZERO_LOW_MIN   = 13,
  parameter int ZERO_LOW_MAX   = 17,
  parameter int BIT_PER_MIN    = 21,
  parameter int BIT_PER_MAX    = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             rxEn,
  input  logic             selStart,
  input  logic             selBit8,
  input  logic             selBit10,
  input  logic             flagClr,
  input  logic             fallSeen,
  input  logic             riseSeen,
  input  logic [CNT_W-1:0] cnt,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             rxEom,
  output rxStrobe_t        strb,
  output logic             flgStart,
  output logic             flgBit8,
  output logic             flgDone,
  output logic             flgErr,
  output logic             irq
);
  localparam logic [CNT_W-1:0] SL_MIN = CNT_W'(START_LOW_MIN);
  localparam logic [CNT_W-1:0] SL_MAX = CNT_W'(START_LOW_MAX);
  localparam logic [CNT_W-1:0] SP_MIN = CNT_W'(START_PER_MIN);
  localparam logic [CNT_W-1:0] SP_MAX = CNT_W'(START_PER_MAX);
  localparam logic [CNT_W-1:0] O_MIN  = CNT_W'(ONE_LOW_MIN);
  localparam logic [CNT_W-1:0] O_MAX  = CNT_W'(ONE_LOW_MAX);
  localparam logic [CNT_W-1:0] Z_MIN  = CNT_W'(ZERO_LOW_MIN);
  localparam logic [CNT_W-1:0] Z_MAX  = CNT_W'(ZERO_LOW_MAX);
  localparam logic [CNT_W-1:0] BP_MIN = CNT_W'(BIT_PER_MIN);
  localparam logic [CNT_W-1:0] BP_MAX = CNT_W'(BIT_PER_MAX);
  localparam logic [IDX_W-1:0] B8_IDX  = IDX_W'(DATA_BITS - 1);
  localparam logic [IDX_W-1:0] B10_IDX = IDX_W'(BLOCK_BITS - 1);

  rxState_t st, nxt;
  logic rxEnQ, gapTick, active, run;
  logic evStart, evB8, evDone, evErr;
  logic isOne, isZero;

  // restart handshake: enable must stay low across a tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEnQ   <= 1'b0;
      gapTick <= 1'b0;
      active  <= 1'b0;
    end else begin
      rxEnQ <= rxEn;
      if (!rxEn) begin
        active <= 1'b0;
        if (tick) gapTick <= 1'b1;
      end else if (!rxEnQ) begin
        active  <= gapTick;
        gapTick <= 1'b0;
      end
    end
  end

  assign run    = rxEn & active;
  assign isOne  = (cnt >= O_MIN) && (cnt <= O_MAX);
  assign isZero = (cnt >= Z_MIN) && (cnt <= Z_MAX);

  always_comb begin
    nxt     = st;
    strb    = '0;
    evStart = 1'b0;
    evB8    = 1'b0;
    evDone  = 1'b0;
    evErr   = 1'b0;
    if (!run) begin
      nxt = ST_IDLE;
    end else if (tick) begin
      unique case (st)
        ST_IDLE:  if (fallSeen) nxt = ST_SLOW;
        ST_SLOW: begin
          if (riseSeen) begin
            if (cnt >= SL_MIN && cnt <= SL_MAX) nxt = ST_SHIGH;
            else evErr = 1'b1;
          end else if (cnt >= SL_MAX) evErr = 1'b1;
        end
        ST_SHIGH: begin
          if (fallSeen) begin
            if (cnt >= SP_MIN && cnt <= SP_MAX) begin
              evStart     = 1'b1;
              strb.bitClr = 1'b1;
              nxt         = ST_BLOW;
            end else evErr = 1'b1;
          end else if (cnt >= SP_MAX) evErr = 1'b1;
        end
        ST_BLOW: begin
          if (riseSeen) begin
            if (isOne || isZero) begin
              strb.bitTake = 1'b1;
              strb.bitVal  = isOne;
              nxt          = ST_BHIGH;
              if (bitIdx == B8_IDX) evB8 = 1'b1;
              if (bitIdx == B10_IDX) begin
                evDone      = 1'b1;
                strb.bitClr = 1'b1;
                if (rxEom) nxt = ST_IDLE;
              end
            end else evErr = 1'b1;
          end else if (cnt >= Z_MAX) evErr = 1'b1;
        end
        ST_BHIGH: begin
          if (fallSeen) begin
            if (cnt >= BP_MIN && cnt <= BP_MAX) nxt = ST_BLOW;
            else evErr = 1'b1;
          end else if (cnt >= BP_MAX) evErr = 1'b1;
        end
        default: nxt = ST_ERR;
      endcase
      if (evErr) nxt = ST_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      flgStart <= 1'b0;
      flgBit8  <= 1'b0;
      flgDone  <= 1'b0;
      flgErr   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      st  <= nxt;
      irq <= (evStart & selStart) | (evB8 & selBit8) | (evDone & selBit10);
      if (flagClr) begin
        flgStart <= 1'b0;
        flgBit8  <= 1'b0;
        flgDone  <= 1'b0;
      end
      if (evStart & selStart) flgStart <= 1'b1;
      if (evB8 & selBit8)     flgBit8  <= 1'b1;
      if (evDone)             flgDone  <= 1'b1;
      if (!rxEn)      flgErr <= 1'b0;
      else if (evErr) flgErr <= 1'b1;
    end
  end
endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx
  import cec_rx_pkg::*;
#(
  parameter int START_LOW_MIN = 35,
  parameter int START_LOW_MAX = 39,
  parameter int START_PER_MIN = 43,
  parameter int START_PER_MAX = 47,
  parameter int ONE_LOW_MIN   = 4,
  parameter int ONE_LOW_MAX   = 8,
  parameter int ZERO_LOW_MIN  = 13,
  parameter int ZERO_LOW_MAX  = 17,
  parameter int BIT_PER_MIN   = 21,
  parameter int BIT_PER_MAX   = 28
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 rxLine,
  input  logic                 rxEn,
  input  logic                 selStart,
  input  logic                 selBit8,
  input  logic                 selBit10,
  input  logic                 flagClr,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxEom,
  output logic                 rxAck,
  output logic                 flgStart,
  output logic                 flgBit8,
  output logic                 flgDone,
  output logic                 flgErr,
  output logic                 irq
);
  localparam int CNT_W = $clog2(START_PER_MAX + 2);

  rxStrobe_t        strb;
  logic             fallSeen, riseSeen;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitIdx;

  cec_rx_datapath #(.CNT_W(CNT_W)) dp (
    .clk(clk), .rstN(rstN), .tick(tick), .rxLine(rxLine), .strb(strb),
    .fallSeen(fallSeen), .riseSeen(riseSeen), .cnt(cnt), .bitIdx(bitIdx),
    .rxData(rxData), .rxEom(rxEom), .rxAck(rxAck)
  );

  cec_rx_ctrl #(
    .CNT_W(CNT_W),
    .START_LOW_MIN(START_LOW_MIN), .START_LOW_MAX(START_LOW_MAX),
    .START_PER_MIN(START_PER_MIN), .START_PER_MAX(START_PER_MAX),
    .ONE_LOW_MIN(ONE_LOW_MIN), .ONE_LOW_MAX(ONE_LOW_MAX),
    .ZERO_LOW_MIN(ZERO_LOW_MIN), .ZERO_LOW_MAX(ZERO_LOW_MAX),
    .BIT_PER_MIN(BIT_PER_MIN), .BIT_PER_MAX(BIT_PER_MAX)
  ) ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .rxEn(rxEn),
    .selStart(selStart), .selBit8(selBit8), .selBit10(selBit10),
    .flagClr(flagClr), .fallSeen(fallSeen), .riseSeen(riseSeen),
    .cnt(cnt), .bitIdx(bitIdx), .rxEom(rxEom), .strb(strb),
    .flgStart(flgStart), .flgBit8(flgBit8), .flgDone(flgDone),
    .flgErr(flgErr), .irq(irq)
  );
endmodule

// File: rtl/cec_rx_checker.sv
module cec_rx_checker
  import cec_rx_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 tick,
  input logic                 rxEn,
  input logic                 flagClr,
  input logic [DATA_BITS-1:0] rxData,
  input logic                 rxEom,
  input logic                 rxAck,
  input logic                 flgStart,
  input logic                 flgBit8,
  input logic                 flgDone,
  input logic                 flgErr,
  input logic                 irq
);
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);  // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flgErr && rxEn) |=> flgErr);  // R7

  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !flgErr);  // R8

  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !irq);  // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !tick) |=> (!flgStart && !flgBit8 && !flgDone));  // R10

  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(rxData) && $stable(rxEom) && $stable(rxAck)));  // R5
endmodule

bind cec_frame_rx cec_rx_checker chk (.*);

// File: tb/cec_frame_rx_test.sv
module cec_frame_rx_test;
  localparam int EV_NONE = 0, EV_START = 1, EV_B8 = 2, EV_EOM = 3, EV_ACK = 4, EV_ERR = 5;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, rxLine = 1'b1, rxEn = 1'b0;
  logic selStart = 1'b1, selBit8 = 1'b1, selBit10 = 1'b1, flagClr = 1'b0;
  logic [7:0] rxData;
  logic rxEom, rxAck, flgStart, flgBit8, flgDone, flgErr, irq;

  cec_frame_rx uut (.*);

  always #10 clk = ~clk;

  int nComp = 0, nBad = 0, cycles = 0;
  bit chkOn = 1'b0, curEn = 1'b0, quiet = 1'b0, edgeMode = 1'b0;
  string phase = "R1";
  logic [7:0] eData = 8'h00, curByte = 8'h00;
  bit eEom = 0, eAck = 0, eStart = 0, eB8 = 0, eDone = 0, eErr = 0, eIrq = 0;
  int pEv = EV_NONE;
  bit pVal = 0, pClr = 0, pErrClr = 0;

  task automatic cmp(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nComp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s (during %s) actual=%h expected=%h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  // compare every output with the model on every clock, away from the edge
  always @(negedge clk) if (chkOn) begin
    cmp(rxData, eData, "R3 data");
    cmp({7'd0, rxEom}, {7'd0, eEom}, "R5 eom");
    cmp({7'd0, rxAck}, {7'd0, eAck}, "R5 ack");
    cmp({7'd0, flgStart}, {7'd0, eStart}, "R2 start flag");
    cmp({7'd0, flgBit8}, {7'd0, eB8}, "R4 bit8 flag");
    cmp({7'd0, flgDone}, {7'd0, eDone}, "R6 done flag");
    cmp({7'd0, flgErr}, {7'd0, eErr}, "R7 error flag");
    cmp({7'd0, irq}, {7'd0, eIrq}, "R11 irq");
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nBad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nComp, nBad);
      $finish;
    end
  end

  // one clock: apply what the previous inputs cause, then drive new inputs
  task automatic step(input bit line, input bit tk, input bit en, input bit clr,
                      input int ev, input bit v);
    @(posedge clk); #4;
    eIrq = 0;
    if (pClr) begin eStart = 0; eB8 = 0; eDone = 0; end
    if (pErrClr) eErr = 0;
    case (pEv)
      EV_START: if (selStart) begin eStart = 1; eIrq = 1; end
      EV_B8:    begin eData = curByte; if (selBit8) begin eB8 = 1; eIrq = 1; end end
      EV_EOM:   eEom = pVal;
      EV_ACK:   begin eAck = pVal; eDone = 1; if (selBit10) eIrq = 1; end
      EV_ERR:   eErr = 1;
      default:  ;
    endcase
    rxLine = line; tick = tk; rxEn = en; flagClr = clr;
    pEv = ev; pVal = v; pClr = clr; pErrClr = !en;
  endtask

  task automatic tk(input bit line, input int ev = EV_NONE, input bit v = 0);
    step(line, 1, curEn, 0, ev, v);
    step(line, 0, curEn, 0, EV_NONE, 0);
  endtask

  task automatic idleTicks(input int n);
    for (int i = 0; i < n; i++) tk(1);
  endtask

  function automatic int lowFor(input bit v, input int i);
    if (!edgeMode) return v ? 6 : 15;
    return v ? ((i % 2) ? 4 : 8) : ((i % 2) ? 13 : 17);
  endfunction

  task automatic sendStart(input int lowN = 37);
    for (int i = 0; i < lowN; i++) tk(0);
    for (int i = 0; i < 45 - lowN; i++) tk(1);
  endtask

  task automatic sendBlock(input logic [7:0] d, input bit eom, input bit ack, input bit first);
    curByte = d;
    for (int i = 0; i < 10; i++) begin
      bit v;
      int lo, evR;
      v  = (i < 8) ? d[7-i] : ((i == 8) ? eom : ack);
      lo = lowFor(v, i);
      evR = quiet ? EV_NONE : (i == 7) ? EV_B8 : (i == 8) ? EV_EOM : (i == 9) ? EV_ACK : EV_NONE;
      for (int j = 0; j < lo; j++) tk(0, (j == 0 && first && i == 0 && !quiet) ? EV_START : EV_NONE);
      for (int j = 0; j < 24 - lo; j++) tk(1, (j == 0) ? evR : EV_NONE, v);
    end
  endtask

  task automatic clearFlags();
    step(1, 0, curEn, 1, EV_NONE, 0);
    step(1, 0, curEn, 0, EV_NONE, 0);
  endtask

  task automatic regap();  // enable low across ticks, then high
    curEn = 0; idleTicks(2);
    curEn = 1; idleTicks(5);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #4 rstN = 1'b1; chkOn = 1'b1;
    phase = "R1 reset";
    idleTicks(3);
    curEn = 1; idleTicks(5);

    // R2 R3 R4 R5 R6: two-block frame, every event selected
    phase = "R6 two-block frame";
    sendStart(); sendBlock(8'hA5, 0, 1, 1); sendBlock(8'h3C, 1, 0, 0);
    idleTicks(30);

    // R10: clear strobe
    phase = "R10 flag clear";
    clearFlags(); idleTicks(2);

    // R4 R3: only the 8th-bit event, decode window edges
    phase = "R4 bit8 only with window edges";
    selStart = 0; selBit10 = 0; edgeMode = 1;
    sendStart(); sendBlock(8'h81, 1, 0, 1);
    idleTicks(20); clearFlags();
    edgeMode = 0;

    // R6: no selects, done flag still set
    phase = "R6 no selects";
    selBit8 = 0;
    sendStart(); sendBlock(8'h00, 0, 0, 1); sendBlock(8'hFF, 1, 1, 0);
    idleTicks(20); clearFlags();
    selStart = 1; selBit8 = 1; selBit10 = 1;

    // R7: bad low width on first data bit
    phase = "R7 bad width";
    sendStart();
    for (int j = 0; j < 10; j++) tk(0, (j == 0) ? EV_START : EV_NONE);
    tk(1, EV_ERR);
    idleTicks(12);
    quiet = 1; sendStart(); sendBlock(8'h55, 1, 0, 1); idleTicks(10);

    // R8 then R9: enable drops for one clock without a tick
    phase = "R9 ignored restart";
    step(1, 0, 0, 0, EV_NONE, 0);
    step(1, 0, 1, 0, EV_NONE, 0);
    clearFlags();
    sendStart(); sendBlock(8'h77, 1, 1, 1); idleTicks(10);
    quiet = 0;
    regap();
    sendStart(); sendBlock(8'h5A, 1, 0, 1); idleTicks(10);

    // R8: abort mid-frame and receive cleanly afterwards
    phase = "R8 abort";
    clearFlags();
    sendStart();
    for (int j = 0; j < 6; j++) tk(0, (j == 0) ? EV_START : EV_NONE);
    for (int j = 0; j < 18; j++) tk(1);
    for (int j = 0; j < 15; j++) tk(0);
    tk(1);
    regap();
    sendStart(); sendBlock(8'hC3, 1, 1, 1); idleTicks(10);

    // R7: low held too long, error on the 18th low tick
    phase = "R7 long low";
    sendStart();
    for (int j = 0; j < 20; j++) tk(0, (j == 0) ? EV_START : ((j == 17) ? EV_ERR : EV_NONE));
    idleTicks(10);
    regap();

    // R2: start low too short
    phase = "R2 short start";
    for (int j = 0; j < 20; j++) tk(0);
    tk(1, EV_ERR);
    idleTicks(10);
    regap();
    idleTicks(3);

    chkOn = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nComp, nBad);
    $finish;
  end
endmodule